// File: doc/BRIEF.md
# HDLC Frame Receiver with Transparency Removal

This block recovers HDLC frames from a receive channel that delivers either whole octets (octet-transparent, asynchronous framing) or single line bits (bit-transparent, synchronous framing). A mode input picks the framing at run time. The block hunts for the start of a frame, then removes the transparency coding: escape octets in octet mode, stuffed zero bits in bit mode. It writes each recovered octet into a receive FIFO interface and marks the last octet of each frame.

Both framings feed one shared frame engine. Each front end turns its input into a small set of events: opening or closing flag, abort, escape, or a completed data octet. The frame engine holds back one octet so that it can tag the final octet once the closing flag arrives. With checking enabled, it runs a CRC-16 over every octet of the frame, frame check sequence included, and compares the result with the fixed residue. Errors are reported as one-cycle pulses that line up with the write of the closing octet.

Top module: `hdlc_rx_deframe`

## Requirements
- R1: While reset is asserted and until the first strobed input after reset, wr_en, wr_eof, err_abort and err_crc are all low.
- R2: Input is discarded until a flag (0x7E) is received. Further flags keep the receiver waiting. The first non-flag unit after a flag starts the frame and is decoded as frame content, not dropped.
- R3: In octet mode (sync_mode=0), an escape octet 0x7D is removed and the octet after it is stored with bit 5 inverted (XOR 0x20). A second 0x7D directly after an escape is treated as data and becomes 0x5D.
- R4: In bit mode (sync_mode=1), bits arrive least significant bit first. A 0 that follows exactly five consecutive 1s is removed. The bit pattern 0,1,1,1,1,1,1,0 is a flag and adds no data.
- R5: A flag received after frame content ends the frame. The last octet decoded before it is written with wr_eof=1, and that flag also counts as the opening flag of the next frame.
- R6: Each decoded octet is written once, in order. The write happens on the clock after the strobe of the next decoded octet or of the flag that closes the frame.
- R7: With crc_en=1, a CRC-16 (reflected polynomial 0x8408, initial value 0xFFFF) is run over all frame octets. If the result at the closing flag differs from 0xF0B8, err_crc pulses together with the end-of-frame write. With crc_en=0, err_crc stays low.
- R8: In bit mode, a seventh consecutive 1 inside a frame aborts it. err_abort pulses for one cycle, and any pending octet is written in the same cycle with wr_eof=1.
- R9: In octet mode, an escape directly followed by a flag aborts the frame in the same way as R8.
- R10: After an abort, the receiver hunts again. No octet is written until a new flag and then a non-flag unit have been received, and the flag that completed an octet-mode abort does not count as an opening flag.
- R11: A cycle with in_valid=0 changes no state and writes nothing.
- R12: err_abort and err_crc never pulse in the same cycle, and wr_eof is only high together with wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe: in_byte or in_bit carries a new unit |
| sync_mode | input | 1 | 0 = octet mode with escapes, 1 = bit mode with zero-bit stuffing |
| crc_en | input | 1 | Enables the end-of-frame CRC residue check |
| in_byte | input | 8 | Received octet (octet mode) |
| in_bit | input | 1 | Received line bit (bit mode) |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Recovered octet |
| wr_eof | output | 1 | Written octet is the last of its frame |
| err_abort | output | 1 | One-cycle pulse: frame aborted |
| err_crc | output | 1 | One-cycle pulse: CRC residue mismatch at frame end |

## Verification
The bench builds the block with its default parameters: flag 0x7E, escape 0x7D with a 0x20 flip, a stuffing run of five, and the 16-bit CRC with residue 0xF0B8. With these defaults, standard frames can be produced in the bench with a real frame check sequence. This covers good and corrupted checksums, data octets that equal the flag or escape codes in octet mode, and runs of 1s that force zero insertion in bit mode. Because the stuffing run is short, line idle, aborts and back-to-back frames that share a flag each take only a handful of bits. All of these cases therefore fit in a few hundred cycles.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int unsigned OCTET_W = 8;

  typedef logic [OCTET_W-1:0] octet_t;

  // Frame engine position
  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_OPEN = 2'd1,
    FR_BODY = 2'd2
  } fr_state_e;

  // One decoded event from either front end, at most one field set
  typedef struct packed {
    logic   flag;
    logic   abort;
    logic   esc;
    logic   data;
    octet_t value;
  } rx_evt_t;

endpackage

// File: rtl/hdlc_rx_octet_fe.sv
module hdlc_rx_octet_fe
  import hdlc_rx_pkg::*;
#(
  parameter octet_t FLAG_OCTET = 8'h7E,
  parameter octet_t ESC_OCTET  = 8'h7D,
  parameter octet_t ESC_FLIP   = 8'h20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  octet_t  in_byte,
  input  logic    hunting,
  output rx_evt_t evt
);

  logic esc_q, esc_d;

  always_comb begin
    evt   = '0;
    esc_d = esc_q;
    if (en) begin
      if (in_byte == FLAG_OCTET) begin
        evt.flag  = !esc_q;
        evt.abort = esc_q;
        esc_d     = 1'b0;
      end else if (in_byte == ESC_OCTET && !esc_q) begin
        evt.esc = !hunting;
        esc_d   = !hunting;
      end else begin
        evt.data  = 1'b1;
        evt.value = esc_q ? (in_byte ^ ESC_FLIP) : in_byte;
        esc_d     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) esc_q <= 1'b0;
    else if (en) esc_q <= esc_d;
  end

endmodule

// File: rtl/hdlc_rx_bit_fe.sv
module hdlc_rx_bit_fe
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    in_bit,
  output rx_evt_t evt
);

  localparam int unsigned RUN_W = $clog2(STUFF_RUN + 3);
  localparam int unsigned CNT_W = $clog2(OCTET_W);
  localparam logic [RUN_W-1:0] L_STUFF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] L_FLAG  = RUN_W'(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0] L_SAT   = RUN_W'(STUFF_RUN + 2);
  localparam logic [CNT_W-1:0] L_LAST  = CNT_W'(OCTET_W - 1);

  logic [RUN_W-1:0] ones_q, ones_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  octet_t           sh_q, sh_d;
  logic             push;

  always_comb begin
    evt    = '0;
    ones_d = ones_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    push   = 1'b0;
    if (en) begin
      if (in_bit) begin
        if (ones_q >= L_FLAG) begin
          evt.abort = (ones_q == L_FLAG);
          ones_d    = L_SAT;
          cnt_d     = '0;
        end else begin
          ones_d = ones_q + 1'b1;
          push   = 1'b1;
        end
      end else begin
        ones_d = '0;
        if (ones_q == L_FLAG) begin
          evt.flag = 1'b1;
          cnt_d    = '0;
        end else if (ones_q != L_STUFF) begin
          push = 1'b1;
        end
      end
      if (push) begin
        sh_d = {in_bit, sh_q[OCTET_W-1:1]};
        if (cnt_q == L_LAST) begin
          evt.data  = 1'b1;
          evt.value = sh_d;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (en) begin
      ones_q <= ones_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned      CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD = 16'hF0B8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  rx_evt_t evt,
  input  logic    crc_en,
  output logic    hunting,
  output logic    wr_en,
  output octet_t  wr_data,
  output logic    wr_eof,
  output logic    err_abort,
  output logic    err_crc
);

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, octet_t d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < OCTET_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  fr_state_e        st_q, st_d;
  octet_t           held_q, held_d;
  logic             hv_q, hv_d;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             we_d, eof_d, abt_d, cerr_d;
  octet_t           wd_d;

  assign hunting = (st_q == FR_HUNT);

  always_comb begin
    st_d   = st_q;
    held_d = held_q;
    hv_d   = hv_q;
    crc_d  = crc_q;
    we_d   = 1'b0;
    wd_d   = held_q;
    eof_d  = 1'b0;
    abt_d  = 1'b0;
    cerr_d = 1'b0;
    unique case (st_q)
      FR_HUNT: begin
        if (evt.flag) st_d = FR_OPEN;
      end
      FR_OPEN: begin
        if (evt.abort) begin
          st_d = FR_HUNT;
        end else if (evt.data) begin
          held_d = evt.value;
          hv_d   = 1'b1;
          crc_d  = crc_step(CRC_INIT, evt.value);
          st_d   = FR_BODY;
        end else if (evt.esc) begin
          hv_d  = 1'b0;
          crc_d = CRC_INIT;
          st_d  = FR_BODY;
        end
      end
      FR_BODY: begin
        if (evt.flag) begin
          we_d   = hv_q;
          eof_d  = hv_q;
          cerr_d = hv_q && crc_en && (crc_q != CRC_GOOD);
          hv_d   = 1'b0;
          st_d   = FR_OPEN;
        end else if (evt.abort) begin
          we_d  = hv_q;
          eof_d = hv_q;
          abt_d = 1'b1;
          hv_d  = 1'b0;
          st_d  = FR_HUNT;
        end else if (evt.data) begin
          we_d   = hv_q;
          held_d = evt.value;
          hv_d   = 1'b1;
          crc_d  = crc_step(crc_q, evt.value);
        end
      end
      default: st_d = FR_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FR_HUNT;
      held_q    <= '0;
      hv_q      <= 1'b0;
      crc_q     <= CRC_INIT;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      wr_eof    <= 1'b0;
      err_abort <= 1'b0;
      err_crc   <= 1'b0;
    end else begin
      st_q      <= st_d;
      held_q    <= held_d;
      hv_q      <= hv_d;
      crc_q     <= crc_d;
      wr_en     <= we_d;
      wr_data   <= wd_d;
      wr_eof    <= eof_d;
      err_abort <= abt_d;
      err_crc   <= cerr_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
  import hdlc_rx_pkg::*;
#(
  parameter octet_t           FLAG_OCTET = 8'h7E,
  parameter octet_t           ESC_OCTET  = 8'h7D,
  parameter octet_t           ESC_FLIP   = 8'h20,
  parameter int unsigned      STUFF_RUN  = 5,
  parameter int unsigned      CRC_W      = 16,
  parameter logic [CRC_W-1:0] CRC_POLY   = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT   = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD   = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       sync_mode,
  input  logic       crc_en,
  input  logic [7:0] in_byte,
  input  logic       in_bit,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       wr_eof,
  output logic       err_abort,
  output logic       err_crc
);

  localparam int unsigned RS_STAGES = 2;

  logic [RS_STAGES-1:0] rs_q;
  logic                 rst_int_n;
  rx_evt_t              evt_oct, evt_bit, evt;
  logic                 hunting;

  // Asynchronous assertion, release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RS_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[RS_STAGES-1];

  hdlc_rx_octet_fe #(
    .FLAG_OCTET(FLAG_OCTET),
    .ESC_OCTET (ESC_OCTET),
    .ESC_FLIP  (ESC_FLIP)
  ) u_oct (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (in_valid && !sync_mode),
    .in_byte(in_byte),
    .hunting(hunting),
    .evt    (evt_oct)
  );

  hdlc_rx_bit_fe #(
    .STUFF_RUN(STUFF_RUN)
  ) u_bit (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (in_valid && sync_mode),
    .in_bit(in_bit),
    .evt   (evt_bit)
  );

  assign evt = sync_mode ? evt_bit : evt_oct;

  hdlc_rx_framer #(
    .CRC_W   (CRC_W),
    .CRC_POLY(CRC_POLY),
    .CRC_INIT(CRC_INIT),
    .CRC_GOOD(CRC_GOOD)
  ) u_frm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt      (evt),
    .crc_en   (crc_en),
    .hunting  (hunting),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_eof   (wr_eof),
    .err_abort(err_abort),
    .err_crc  (err_crc)
  );

endmodule

// File: rtl/hdlc_rx_deframe_chk.sv
module hdlc_rx_deframe_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic crc_en,
  input logic wr_en,
  input logic wr_eof,
  input logic err_abort,
  input logic err_crc
);

  // R11: a write needs a strobed input on the clock before
  p_write_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid));

  // R9: an abort pulse also follows a strobed input
  p_abort_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |-> $past(in_valid));

  // R7: a CRC error is only possible with checking enabled
  p_crc_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |-> $past(crc_en));

  // R5: a CRC error marks an end-of-frame write
  p_crc_at_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |-> (wr_en && wr_eof));

  // R12: end-of-frame only with a write, and no double error
  p_eof_with_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eof |-> wr_en);
  p_errors_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_abort && err_crc));

  // R10: the cycle after an abort writes nothing and raises no new abort
  p_hunt_after_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |=> (!wr_en && !err_abort));

endmodule

bind hdlc_rx_deframe hdlc_rx_deframe_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .crc_en   (crc_en),
  .wr_en    (wr_en),
  .wr_eof   (wr_eof),
  .err_abort(err_abort),
  .err_crc  (err_crc)
);

// File: tb/tb_hdlc_rx_deframe.sv
module tb_hdlc_rx_deframe;

  typedef struct {
    bit         v;
    bit         sm;
    bit         ce;
    logic [7:0] b;
    bit         bi;
  } stim_t;

  logic       clk, rst_n, in_valid, sync_mode, crc_en, in_bit;
  logic [7:0] in_byte, wr_data;
  logic       wr_en, wr_eof, err_abort, err_crc;

  int n_checks = 0;
  int n_err    = 0;

  stim_t sq[$];
  string tq[$];

  // reference model state
  int         m_st;      // 0 hunting, 1 after flag, 2 inside frame
  int         m_held;    // -1 when nothing pending
  int         m_crc;
  bit         m_esc;
  int         m_ones;
  bit         bq[$];
  logic [11:0] exp_v;
  string      exp_tag;

  hdlc_rx_deframe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sync_mode(sync_mode),
    .crc_en(crc_en), .in_byte(in_byte), .in_bit(in_bit), .wr_en(wr_en),
    .wr_data(wr_data), .wr_eof(wr_eof), .err_abort(err_abort), .err_crc(err_crc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int crc_upd(int c, logic [7:0] d);
    int r = c;
    for (int i = 0; i < 8; i++) begin
      if (((r ^ d[i]) & 1) != 0) r = (r >> 1) ^ 'h8408;
      else                       r = r >> 1;
    end
    return r & 'hFFFF;
  endfunction

  task automatic model_reset();
    m_st = 0; m_held = -1; m_crc = 'hFFFF; m_esc = 0; m_ones = 0;
    bq.delete();
    exp_v = '0;
  endtask

  // behavioural expectation for the outputs one clock after s is applied
  task automatic model(stim_t s);
    int         ev = 0;  // 1 flag, 2 abort, 3 data, 4 escape
    logic [7:0] val = 8'h00;
    bit we = 0, eof = 0, ab = 0, ce = 0;
    logic [7:0] wd = 8'h00;
    if (s.v && !s.sm) begin
      if (s.b == 8'h7E) begin ev = m_esc ? 2 : 1; m_esc = 0; end
      else if (s.b == 8'h7D && !m_esc) begin
        if (m_st != 0) begin m_esc = 1; ev = 4; end
      end else begin ev = 3; val = m_esc ? (s.b ^ 8'h20) : s.b; m_esc = 0; end
    end else if (s.v) begin
      if (s.bi) begin
        if (m_ones >= 6) begin
          if (m_ones == 6) ev = 2;
          m_ones = 7; bq.delete();
        end else begin m_ones++; bq.push_back(1'b1); end
      end else begin
        if (m_ones == 6) begin ev = 1; bq.delete(); end
        else if (m_ones != 5) bq.push_back(1'b0);
        m_ones = 0;
      end
      if (bq.size() == 8) begin
        for (int i = 0; i < 8; i++) val[i] = bq[i];
        bq.delete(); ev = 3;
      end
    end
    if (m_st == 0) begin
      if (ev == 1) m_st = 1;
    end else if (m_st == 1) begin
      if (ev == 2) m_st = 0;
      else if (ev == 3) begin m_held = val; m_crc = crc_upd('hFFFF, val); m_st = 2; end
      else if (ev == 4) begin m_held = -1; m_crc = 'hFFFF; m_st = 2; end
    end else begin
      if (ev == 1 || ev == 2) begin
        if (m_held >= 0) begin we = 1; eof = 1; wd = m_held[7:0]; end
        if (ev == 1) ce = (m_held >= 0) && s.ce && (m_crc != 'hF0B8);
        else         ab = 1;
        m_held = -1;
        m_st = (ev == 1) ? 1 : 0;
      end else if (ev == 3) begin
        if (m_held >= 0) begin we = 1; wd = m_held[7:0]; end
        m_held = val; m_crc = crc_upd(m_crc, val);
      end
    end
    exp_v = {we, wd, eof, ab, ce};
  endtask

  task automatic check_now();
    logic [11:0] act;
    act = {wr_en, wr_en ? wr_data : 8'h00, wr_eof, err_abort, err_crc};
    n_checks++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: got en/data/eof/abt/crc=%h expected %h", exp_tag, act, exp_v);
    end
  endtask

  task automatic put(bit v, bit sm, bit ce, logic [7:0] b, bit bi, string t);
    stim_t s;
    s.v = v; s.sm = sm; s.ce = ce; s.b = b; s.bi = bi;
    sq.push_back(s); tq.push_back(t);
  endtask

  task automatic put_oct(logic [7:0] b, bit ce, string t);
    put(1, 0, ce, b, 0, t);
  endtask

  task automatic put_bit_octet(logic [7:0] b, bit stuff, bit ce, string t, inout int run);
    for (int i = 0; i < 8; i++) begin
      put(1, 1, ce, 8'h00, b[i], t);
      if (stuff) begin
        run = b[i] ? run + 1 : 0;
        if (run == 5) begin put(1, 1, ce, 8'h00, 1'b0, t); run = 0; end
      end
    end
  endtask

  task automatic oct_frame(logic [7:0] d[$], bit good, bit ce, string t);
    int         c = 'hFFFF;
    logic [7:0] all[$];
    foreach (d[i]) begin c = crc_upd(c, d[i]); all.push_back(d[i]); end
    c = (~c) & 'hFFFF;
    if (!good) c = c ^ 1;
    all.push_back(c[7:0]); all.push_back(c[15:8]);
    foreach (all[i]) begin
      if (all[i] == 8'h7E || all[i] == 8'h7D) begin
        put_oct(8'h7D, ce, t); put_oct(all[i] ^ 8'h20, ce, t);
      end else put_oct(all[i], ce, t);
    end
    put_oct(8'h7E, ce, t);
  endtask

  task automatic bit_frame(logic [7:0] d[$], bit good, bit ce, string t);
    int         c = 'hFFFF;
    int         run = 0;
    logic [7:0] all[$];
    foreach (d[i]) begin c = crc_upd(c, d[i]); all.push_back(d[i]); end
    c = (~c) & 'hFFFF;
    if (!good) c = c ^ 1;
    all.push_back(c[7:0]); all.push_back(c[15:8]);
    foreach (all[i]) put_bit_octet(all[i], 1, ce, t, run);
    put_bit_octet(8'h7E, 0, ce, t, run);
  endtask

  task automatic run_queue();
    while (sq.size() > 0) begin
      stim_t s;
      string t;
      @(negedge clk);
      check_now();
      s = sq.pop_front(); t = tq.pop_front();
      in_valid = s.v; sync_mode = s.sm; crc_en = s.ce; in_byte = s.b; in_bit = s.bi;
      model(s);
      exp_tag = t;
    end
    @(negedge clk);
    check_now();
    in_valid = 1'b0;
    exp_v = '0;
  endtask

  task automatic do_reset(bit sm);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; sync_mode = sm; crc_en = 1'b0;
    in_byte = 8'h00; in_bit = 1'b0;
    model_reset();
    exp_tag = "R1";
    repeat (3) @(negedge clk);
    check_now();   // R1 outputs quiet in reset
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) put(0, sm, 0, 8'h00, 0, "R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    int run;
    rst_n = 1'b0; in_valid = 1'b0; sync_mode = 1'b0; crc_en = 1'b0;
    in_byte = 8'h00; in_bit = 1'b0;
    model_reset();
    exp_tag = "R1";

    // ---------------- octet mode ----------------
    do_reset(0);
    // R2: garbage before any flag is dropped
    put_oct(8'h12, 1, "R2"); put_oct(8'h7D, 1, "R2"); put_oct(8'h55, 1, "R2");
    put_oct(8'h7E, 1, "R2"); put_oct(8'h7E, 1, "R2"); put_oct(8'h7E, 1, "R2");
    // R3 R5 R7: good frame with flag/escape values inside
    d = '{8'h01, 8'h7E, 8'h7D, 8'h20, 8'hAA};
    oct_frame(d, 1, 1, "R3");
    // R5 R7: closing flag opens the next frame; bad checksum
    d = '{8'hC3, 8'h5E};
    oct_frame(d, 0, 1, "R7");
    // R7: checking disabled, bad checksum stays silent
    d = '{8'h0F};
    oct_frame(d, 0, 0, "R7");
    // R11: gaps inside a frame
    put_oct(8'h99, 1, "R11"); put(0, 0, 1, 8'h7E, 0, "R11");
    put(0, 0, 1, 8'h7D, 0, "R11"); put_oct(8'h98, 1, "R11");
    put(0, 0, 1, 8'h7E, 0, "R11"); put_oct(8'h7E, 1, "R6");
    // R3: double escape gives 0x5D
    put_oct(8'h7D, 0, "R3"); put_oct(8'h7D, 0, "R3"); put_oct(8'h41, 0, "R3");
    put_oct(8'h7E, 0, "R3");
    // R9 R10: escape then flag aborts; flag does not reopen
    put_oct(8'h11, 0, "R9"); put_oct(8'h22, 0, "R9");
    put_oct(8'h7D, 0, "R9"); put_oct(8'h7E, 0, "R9");
    put_oct(8'h33, 0, "R10"); put_oct(8'h34, 0, "R10");
    put_oct(8'h7E, 0, "R10"); put_oct(8'h44, 0, "R10"); put_oct(8'h7E, 0, "R10");
    run_queue();

    // ---------------- bit mode ----------------
    do_reset(1);
    run = 0;
    for (int i = 0; i < 10; i++) put(1, 1, 1, 8'h00, 1'b1, "R2");
    put_bit_octet(8'h7E, 0, 1, "R2", run);
    put_bit_octet(8'h7E, 0, 1, "R2", run);
    // R4 R5 R7: stuffing-heavy frame, good checksum
    d = '{8'hFF, 8'h3E, 8'h7E, 8'h7D, 8'h00};
    bit_frame(d, 1, 1, "R4");
    // R7: shared flag, bad checksum
    d = '{8'hF8, 8'h1F};
    bit_frame(d, 0, 1, "R7");
    // R8: seven ones inside a frame
    put_bit_octet(8'h5A, 0, 1, "R8", run);
    for (int i = 0; i < 8; i++) put(1, 1, 1, 8'h00, 1'b1, "R8");
    // R10: data without flag is dropped, then flag and frame
    put_bit_octet(8'h24, 0, 1, "R10", run);
    for (int i = 0; i < 8; i++) put(1, 1, 1, 8'h00, 1'b1, "R10");
    put_bit_octet(8'h7E, 0, 1, "R10", run);
    d = '{8'h81};
    bit_frame(d, 1, 1, "R10");
    // R11 R6: gaps between bits and trailing idle
    put(0, 1, 1, 8'h00, 1'b1, "R11");
    put_bit_octet(8'h42, 0, 0, "R6", run);
    put(0, 1, 0, 8'h00, 1'b0, "R11");
    put_bit_octet(8'h7E, 0, 0, "R6", run);
    for (int i = 0; i < 9; i++) put(1, 1, 0, 8'h00, 1'b1, "R12");
    run_queue();

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule